// File: doc/BRIEF.md
# Dual-Operand Forwarding Pipelined Multiplier

This block is an unsigned 8 by 8 multiplier built as a five-stage pipeline. It takes both operands two bits per stage, least significant slice first. Because of that, a multiply can start before the multiplies that produce its operands have finished. Once stage k of a multiply has completed, its product bits [2k-1:0] are final. Those bits are handed, slice by slice, to later multiplies that name it as a source. This covers three cases: only the first operand depends on an earlier multiply, only the second does, or both do.

Stage k (k = 1..4) takes the k-th two-bit slice of each operand. It adds three terms into a carry-save pair of rows: the new slice of one operand times the bits already received of the other, the same the other way round, and the product of the two new slices. It then resolves the low 2k bits to binary. The last stage propagates carries through the high byte.

Each operand has a source select. One value takes the operand from the issue port. Values 1 to 4 take it from the low byte of a multiply issued that many cycles earlier. Idle cycles count towards that distance. Choosing the select values is the job of logic outside this block.

Top module: `dfm_mul`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, res_valid is 0 and res_prod is 0. A reset applied while multiplies are in flight discards them, so none of them ever produces a result.
- R2: An issue accepted at clock edge E (iss_valid high) raises res_valid after edge E+4, for exactly one cycle per issue. Back-to-back issues give back-to-back results in issue order.
- R3: When both source selects are 0, res_prod equals iss_a times iss_b as an unsigned 16-bit product.
- R4: A source select d in 1..4 makes that operand equal to bits [7:0] of the product of the multiply accepted d edges earlier. Idle cycles count in d.
- R5: When exactly one operand is forwarded, the product is correct at distances 1 and 2, with either the first or the second operand being the forwarded one.
- R6: When both operands are forwarded, the product is correct. This includes one operand at distance 2 and the other at distance 1, and both operands from the same multiply at distance 1. The result appears one cycle after the result of the distance-1 producer.
- R7: Distances 3 and 4 give correct products, even though the producer has already left the pipeline before the consumer needs its upper slices.
- R8: While res_valid is 0, res_prod keeps the last product.
- R9: The port value of an operand whose select is 1..4 has no effect on the product.
- R10: Select values 5, 6 and 7 behave like 0: that operand is taken from the issue port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue a multiply this cycle |
| iss_a | input | 8 | First operand from the register path |
| iss_b | input | 8 | Second operand from the register path |
| iss_a_src | input | 3 | First operand source: 0 port, 1..4 distance to producer |
| iss_b_src | input | 3 | Second operand source: 0 port, 1..4 distance to producer |
| res_valid | output | 1 | Product valid |
| res_prod | output | 16 | Unsigned product |

## Verification
Every product is due on the outputs after the fifth rising edge counting the edge that accepts the issue. It stays on the outputs until the next valid product. The stimulus table is issued one entry per cycle. The checking process starts on the same falling edge as the driver and waits exactly five falling edges before it compares entry 0. It then moves forward by one falling edge per entry, so every check lands in the cycle of its own result. The directed tests also check the four cycles before a result, and the cycles after it, to confirm the latency and that the product holds.

// File: rtl/dfm_pkg.sv
`timescale 1ns/1ps
package dfm_pkg;
    parameter int unsigned OP_W  = 8;
    parameter int unsigned DIG_W = 2;
    localparam int unsigned NDIG  = OP_W / DIG_W;
    localparam int unsigned PR_W  = 2 * OP_W;
    localparam int unsigned SEL_W = $clog2(NDIG + 1);
    localparam int unsigned VIS_N = 2 * NDIG - 1;
    localparam int unsigned HIST_N = NDIG - 2;

    // One multiply in flight: operand bits known so far, source selects,
    // carry-save rows and the carry out of the resolved low window.
    typedef struct packed {
        logic             vld;
        logic [OP_W-1:0]  a_val;
        logic [OP_W-1:0]  b_val;
        logic [SEL_W-1:0] a_src;
        logic [SEL_W-1:0] b_src;
        logic [PR_W-1:0]  sum;
        logic [PR_W-1:0]  cry;
        logic             cin;
    } lane_t;
endpackage

// File: rtl/dfm_pick.sv
`timescale 1ns/1ps
module dfm_pick
    import dfm_pkg::*;
#(
    parameter int unsigned K = 1
) (
    input  logic [VIS_N-1:0][PR_W-1:0] vis,
    input  logic [SEL_W-1:0]           src,
    input  logic [OP_W-1:0]            port_val,
    output logic [DIG_W-1:0]           dig
);
    localparam int unsigned SH = (K - 1) * DIG_W;

    always_comb begin
        dig = port_val[SH +: DIG_W];
        if (src != '0 && int'(src) <= int'(NDIG)) begin
            for (int j = 0; j < int'(VIS_N); j++) begin
                if (int'(src) + int'(K) - 2 == j) begin
                    dig = vis[j][SH +: DIG_W];
                end
            end
        end
    end
endmodule

// File: rtl/dfm_stage.sv
`timescale 1ns/1ps
module dfm_stage
    import dfm_pkg::*;
#(
    parameter int unsigned K = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lane_t            lane_i,
    input  logic [DIG_W-1:0] a_dig,
    input  logic [DIG_W-1:0] b_dig,
    output lane_t            lane_q
);
    localparam int unsigned SH  = (K - 1) * DIG_W;
    localparam int unsigned LOW = K * DIG_W;
    localparam logic [PR_W-1:0] PRI_M = (PR_W'(1) << SH) - PR_W'(1);
    localparam logic [PR_W-1:0] LOW_M = (PR_W'(1) << LOW) - PR_W'(1);

    lane_t lane_d;
    logic [PR_W-1:0] a_pri, b_pri, terms, s_row, c_row;
    logic [PR_W:0]   low_w;

    always_comb begin
        lane_d = lane_i;
        a_pri  = PR_W'(lane_i.a_val) & PRI_M;
        b_pri  = PR_W'(lane_i.b_val) & PRI_M;
        terms  = ((PR_W'(a_dig) * b_pri + PR_W'(b_dig) * a_pri) << SH)
               + ((PR_W'(a_dig) * PR_W'(b_dig)) << (2 * SH))
               + (PR_W'(lane_i.cin) << SH);
        s_row  = lane_i.sum ^ lane_i.cry ^ terms;
        c_row  = ((lane_i.sum & lane_i.cry) | (lane_i.sum & terms)
                 | (lane_i.cry & terms)) << 1;
        low_w  = {1'b0, s_row & LOW_M} + {1'b0, c_row & LOW_M};
        lane_d.sum = (s_row & ~LOW_M) | (low_w[PR_W-1:0] & LOW_M);
        lane_d.cry = c_row & ~LOW_M;
        lane_d.cin = low_w[LOW];
        lane_d.a_val[SH +: DIG_W] = a_dig;
        lane_d.b_val[SH +: DIG_W] = b_dig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_d;
    end
endmodule

// File: rtl/dfm_cpa.sv
`timescale 1ns/1ps
module dfm_cpa
    import dfm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vld_i,
    input  logic [PR_W-1:0] sum_i,
    input  logic [PR_W-1:0] cry_i,
    input  logic            cin_i,
    output logic            vld_q,
    output logic [PR_W-1:0] prod_q
);
    typedef struct packed {
        logic            vld;
        logic [PR_W-1:0] prod;
    } out_t;

    out_t out_d, out_q;
    logic [OP_W-1:0] hi;

    always_comb begin
        hi = sum_i[PR_W-1:OP_W] + cry_i[PR_W-1:OP_W] + OP_W'(cin_i);
        out_d.vld  = vld_i;
        out_d.prod = vld_i ? {hi, sum_i[OP_W-1:0]} : out_q.prod;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign vld_q  = out_q.vld;
    assign prod_q = out_q.prod;
endmodule

// File: rtl/dfm_mul.sv
`timescale 1ns/1ps
module dfm_mul
    import dfm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [OP_W-1:0]  iss_a,
    input  logic [OP_W-1:0]  iss_b,
    input  logic [SEL_W-1:0] iss_a_src,
    input  logic [SEL_W-1:0] iss_b_src,
    output logic             res_valid,
    output logic [PR_W-1:0]  res_prod
);
    lane_t lin  [NDIG];
    lane_t st_q [NDIG];
    logic [VIS_N-1:0][PR_W-1:0] vis;
    logic [HIST_N-1:0][PR_W-1:0] hist_d, hist_q;

    // Everything a consumer can read its next slice from, indexed by how
    // many stages the producer has completed (minus one).
    always_comb begin
        for (int j = 0; j < int'(NDIG); j++) vis[j] = st_q[j].sum;
        vis[NDIG] = res_prod;
        for (int h = 0; h < int'(HIST_N); h++) vis[NDIG + 1 + h] = hist_q[h];
    end

    always_comb begin
        hist_d[0] = res_prod;
        for (int h = 1; h < int'(HIST_N); h++) hist_d[h] = hist_q[h-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    for (genvar g = 1; g <= int'(NDIG); g++) begin : g_stage
        logic [DIG_W-1:0] a_dig, b_dig;

        if (g == 1) begin : g_head
            always_comb begin
                lin[0]       = '0;
                lin[0].vld   = iss_valid;
                lin[0].a_val = iss_a;
                lin[0].b_val = iss_b;
                lin[0].a_src = iss_a_src;
                lin[0].b_src = iss_b_src;
            end
        end else begin : g_body
            assign lin[g-1] = st_q[g-2];
        end

        dfm_pick #(.K(g)) u_pick_a (
            .vis(vis), .src(lin[g-1].a_src), .port_val(lin[g-1].a_val), .dig(a_dig)
        );
        dfm_pick #(.K(g)) u_pick_b (
            .vis(vis), .src(lin[g-1].b_src), .port_val(lin[g-1].b_val), .dig(b_dig)
        );
        dfm_stage #(.K(g)) u_stage (
            .clk(clk), .rst_n(rst_n), .lane_i(lin[g-1]),
            .a_dig(a_dig), .b_dig(b_dig), .lane_q(st_q[g-1])
        );
    end

    dfm_cpa u_cpa (
        .clk(clk), .rst_n(rst_n),
        .vld_i(st_q[NDIG-1].vld), .sum_i(st_q[NDIG-1].sum),
        .cry_i(st_q[NDIG-1].cry), .cin_i(st_q[NDIG-1].cin),
        .vld_q(res_valid), .prod_q(res_prod)
    );
endmodule

// File: rtl/dfm_checker.sv
`timescale 1ns/1ps
module dfm_checker
    import dfm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [OP_W-1:0]  iss_a,
    input logic [OP_W-1:0]  iss_b,
    input logic [SEL_W-1:0] iss_a_src,
    input logic [SEL_W-1:0] iss_b_src,
    input logic             res_valid,
    input logic [PR_W-1:0]  res_prod
);
    logic            vld_q  [NDIG+1];
    logic            port_q [NDIG+1];
    logic [OP_W-1:0] ea_q   [NDIG+1];
    logic [OP_W-1:0] eb_q   [NDIG+1];
    logic [OP_W-1:0] ea_now, eb_now;
    logic [PR_W-1:0] ref_p;

    function automatic logic [OP_W-1:0] low_of(input int d, input logic [OP_W-1:0] a,
                                               input logic [OP_W-1:0] b);
        logic [PR_W-1:0] p;
        p = PR_W'(a) * PR_W'(b);
        return p[OP_W-1:0];
    endfunction

    always_comb begin
        ea_now = iss_a;
        eb_now = iss_b;
        for (int d = 1; d <= int'(NDIG); d++) begin
            if (int'(iss_a_src) == d) ea_now = low_of(d, ea_q[d-1], eb_q[d-1]);
            if (int'(iss_b_src) == d) eb_now = low_of(d, ea_q[d-1], eb_q[d-1]);
        end
        ref_p = PR_W'(ea_q[NDIG]) * PR_W'(eb_q[NDIG]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= int'(NDIG); i++) begin
                vld_q[i] <= 1'b0; port_q[i] <= 1'b0; ea_q[i] <= '0; eb_q[i] <= '0;
            end
        end else begin
            vld_q[0]  <= iss_valid;
            port_q[0] <= (iss_a_src == '0) && (iss_b_src == '0);
            ea_q[0]   <= ea_now;
            eb_q[0]   <= eb_now;
            for (int i = 1; i <= int'(NDIG); i++) begin
                vld_q[i] <= vld_q[i-1]; port_q[i] <= port_q[i-1];
                ea_q[i]  <= ea_q[i-1];  eb_q[i]   <= eb_q[i-1];
            end
        end
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) res_valid == vld_q[NDIG]); // R2
    AST_PORT_PRODUCT:   assert property (@(posedge clk) disable iff (!rst_n) (res_valid && port_q[NDIG]) |-> res_prod == ref_p); // R3
    AST_FWD_PRODUCT:    assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !port_q[NDIG]) |-> res_prod == ref_p); // R4
    AST_PROD_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> $stable(res_prod)); // R8
endmodule

bind dfm_mul dfm_checker u_dfm_checker (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_a(iss_a), .iss_b(iss_b),
    .iss_a_src(iss_a_src), .iss_b_src(iss_b_src), .res_valid(res_valid), .res_prod(res_prod)
);

// File: tb/test_dfm_mul.sv
`timescale 1ns/1ps
module test_dfm_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [7:0]  iss_a = '0, iss_b = '0;
    logic [2:0]  iss_a_src = '0, iss_b_src = '0;
    logic        res_valid;
    logic [15:0] res_prod;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dfm_mul i_dfm_mul (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_a(iss_a), .iss_b(iss_b),
        .iss_a_src(iss_a_src), .iss_b_src(iss_b_src), .res_valid(res_valid), .res_prod(res_prod)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  b;
        logic [2:0]  sa;
        logic [2:0]  sb;
        logic [15:0] exp;
    } vec_t;

    // Issued one per cycle; forwarded values are low bytes of earlier rows.
    localparam vec_t TBL [10] = '{
        '{8'h0D, 8'h0B, 3'd0, 3'd0, 16'h008F},  // R3 port x port
        '{8'h03, 8'h55, 3'd0, 3'd1, 16'h01AD},  // R5 R9 second operand from d1
        '{8'hFF, 8'h02, 3'd1, 3'd0, 16'h015A},  // R5 R9 first operand from d1
        '{8'h77, 8'h66, 3'd2, 3'd1, 16'h3CD2},  // R6 d2 x d1
        '{8'h00, 8'h00, 3'd1, 3'd1, 16'hAC44},  // R6 same producer on both
        '{8'hFF, 8'hFF, 3'd0, 3'd0, 16'hFE01},  // R3 largest operands
        '{8'h11, 8'h22, 3'd3, 3'd4, 16'h49D4},  // R7 d3 x d4
        '{8'h99, 8'h00, 3'd4, 3'd0, 16'h0000},  // R7 d4 times zero
        '{8'h12, 8'h34, 3'd6, 3'd0, 16'h03A8},  // R10 select 6 means port
        '{8'hEE, 8'hFF, 3'd1, 3'd7, 16'hA758}   // R10 select 7 means port
    };

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] a, input logic [7:0] b,
                         input logic [2:0] sa, input logic [2:0] sb);
        iss_valid = v; iss_a = a; iss_b = b; iss_a_src = sa; iss_b_src = sb;
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        report();
        $finish;
    end

    initial begin
        // R1: quiet in reset and right after release
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R1 valid in reset", 16'(res_valid), 16'h0);
        chk(res_prod == 16'h0, "R1 product in reset", res_prod, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R1 valid after release", 16'(res_valid), 16'h0);

        // Table walk: back-to-back issues, results due five falling edges later
        fork
            begin
                for (int i = 0; i < 10; i++) begin
                    drive(1'b1, TBL[i].a, TBL[i].b, TBL[i].sa, TBL[i].sb);
                    @(negedge clk);
                end
                drive(1'b0, 8'h0, 8'h0, 3'd0, 3'd0);
            end
            begin
                repeat (5) @(negedge clk);
                for (int i = 0; i < 10; i++) begin
                    chk(res_valid == 1'b1, "R2 valid in table", 16'(res_valid), 16'h1);
                    chk(res_prod == TBL[i].exp, "R3 R4 table product", res_prod, TBL[i].exp);
                    @(negedge clk);
                end
                chk(res_valid == 1'b0, "R2 one result per issue", 16'(res_valid), 16'h0);
            end
        join
        repeat (3) @(negedge clk);

        // R2 latency of a lone multiply, R8 hold afterwards
        drive(1'b1, 8'h07, 8'h09, 3'd0, 3'd0);
        @(negedge clk);
        drive(1'b0, 8'h0, 8'h0, 3'd0, 3'd0);
        for (int c = 1; c <= 4; c++) begin
            chk(res_valid == 1'b0, "R2 not early", 16'(res_valid), 16'h0);
            @(negedge clk);
        end
        chk(res_valid == 1'b1, "R2 due on time", 16'(res_valid), 16'h1);
        chk(res_prod == 16'h003F, "R3 lone product", res_prod, 16'h003F);
        @(negedge clk);
        chk(res_valid == 1'b0, "R2 single pulse", 16'(res_valid), 16'h0);
        chk(res_prod == 16'h003F, "R8 hold", res_prod, 16'h003F);
        @(negedge clk);
        chk(res_prod == 16'h003F, "R8 hold second cycle", res_prod, 16'h003F);

        // R4: idle cycles count in the distance
        drive(1'b1, 8'h10, 8'h0F, 3'd0, 3'd0);     // 0x00F0
        @(negedge clk);
        drive(1'b0, 8'h0, 8'h0, 3'd0, 3'd0);
        @(negedge clk);
        drive(1'b1, 8'hAB, 8'h03, 3'd2, 3'd0);     // 0xF0*3
        @(negedge clk);
        drive(1'b1, 8'hCD, 8'hEF, 3'd3, 3'd1);     // 0xF0*0xD0
        @(negedge clk);
        drive(1'b0, 8'h0, 8'h0, 3'd0, 3'd0);
        @(negedge clk);
        chk(res_prod == 16'h00F0, "R4 producer", res_prod, 16'h00F0);
        @(negedge clk);
        chk(res_valid == 1'b0, "R4 bubble slot", 16'(res_valid), 16'h0);
        @(negedge clk);
        chk(res_prod == 16'h02D0, "R4 distance over idle", res_prod, 16'h02D0);
        @(negedge clk);
        chk(res_prod == 16'hC300, "R7 R6 d3 and d1 after idle", res_prod, 16'hC300);
        repeat (2) @(negedge clk);

        // R1: reset during flight discards work
        drive(1'b1, 8'h21, 8'h43, 3'd0, 3'd0);
        @(negedge clk);
        drive(1'b0, 8'h0, 8'h0, 3'd0, 3'd0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 6; c++) begin
            chk(res_valid == 1'b0, "R1 flushed by reset", 16'(res_valid), 16'h0);
            @(negedge clk);
        end
        chk(res_prod == 16'h0, "R1 product cleared", res_prod, 16'h0);

        report();
        $finish;
    end
endmodule